// File: doc/BRIEF.md
# Playback Status Output Generator

This block produces the status waveforms that accompany voice playback and places them on three general-purpose output pins. It watches the player's busy flag, a one-cycle end-of-playback event together with the stop-pulse enable of the group that has just finished, and a sample-rate tick. From these it builds four signals: a busy level, a delayed stop pulse of fixed width, and two complementary LED flash phases.

A two-bit whole-chip option code selects which three of these four signals reach the pins, and in what order. Every duration is counted in sample ticks, so when the sampling frequency changes all timing scales with it. The defaults give a 2-tick stop delay, a 512-tick stop pulse and an LED half-period of 1333 ticks. At an 8 kHz sample rate these are about 250 µs, 64 ms and a 3 Hz flash.

Top module: `play_status_gen`

## Requirements
- R1: Option codes 0 and 1 drive pins[0]=LED2, pins[1]=LED1 and pins[2]=BUSY. pins[0] is the first output pin.
- R2: Option code 2 drives pins[0]=STOP, pins[1]=LED1 and pins[2]=LED2.
- R3: Option code 3 drives pins[0]=LED1, pins[1]=BUSY and pins[2]=STOP.
- R4: BUSY equals the busy input in the same cycle, for the whole of playback.
- R5: An enabled end event arms the stop logic. STOP rises in the cycle after the edge that accepts the STOP_DELAY-th tick following the event.
- R6: STOP stays high while STOP_WIDTH ticks are accepted and falls after the edge that accepts the last of them.
- R7: An end event whose stop enable is low produces no STOP pulse. If such an event arrives while a stop sequence is pending, it cancels that sequence.
- R8: A high busy input while a stop sequence is waiting or pulsing removes STOP in that same cycle and abandons the sequence.
- R9: While busy, LED1 starts low and toggles after every LED_HALF accepted ticks, so after k ticks it equals floor(k/LED_HALF) mod 2.
- R10: While busy, LED2 is the inverse of LED1.
- R11: When busy is low, LED1 and LED2 are low in the same cycle, and the next playback restarts the flash phase from zero.
- R12: After reset, with busy low and no event, all three pins are low for every option code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle sample-rate tick |
| busy_i | input | 1 | Player busy flag |
| play_end_i | input | 1 | One-cycle end-of-playback event |
| stop_en_i | input | 1 | Stop-pulse enable of the finished group, sampled with play_end_i |
| opt_i | input | 2 | Whole-chip output option code |
| pins_o | output | 3 | Status pins, bit 0 = first pin |

## Verification
The stop pulse of one playback and the start of the next can fall in the same cycle. When they do, the busy flag and the stop pulse compete, and the stop pulse must give way at once. The bench provokes this by arming a stop sequence, letting the pulse rise, and then raising busy at a falling edge. It judges the result from the pins before the next rising edge: STOP must already be low on every option code. It then checks that the sequence does not come back after busy falls again. An end event that arrives while a sequence is pending, with the enable low, is checked the same way.

// File: rtl/play_status_pkg.sv
package play_status_pkg;

    typedef enum logic [1:0] {
        SP_IDLE  = 2'd0,
        SP_WAIT  = 2'd1,
        SP_PULSE = 2'd2
    } stop_state_e;

    typedef struct packed {
        logic busy;
        logic stop;
        logic led_a;
        logic led_b;
    } status_sig_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Returns {pin2, pin1, pin0}
    function automatic logic [2:0] route_pins(logic [1:0] opt, status_sig_t s);
        logic [2:0] p;
        case (opt)
            2'd2:    p = {s.led_b, s.led_a, s.stop};
            2'd3:    p = {s.stop, s.busy, s.led_a};
            default: p = {s.busy, s.led_a, s.led_b};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/stop_pulse_gen.sv
module stop_pulse_gen
    import play_status_pkg::*;
#(
    parameter int unsigned STOP_DELAY = 2,
    parameter int unsigned STOP_WIDTH = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic busy_i,
    input  logic play_end_i,
    input  logic stop_en_i,
    output logic stop_o
);
    localparam int unsigned CW = $clog2(max2(STOP_DELAY, STOP_WIDTH) + 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(STOP_DELAY - 1);
    localparam logic [CW-1:0] WID_LAST = CW'(STOP_WIDTH - 1);

    stop_state_e    st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (play_end_i) begin
            st_d  = stop_en_i ? SP_WAIT : SP_IDLE;
            cnt_d = '0;
        end else if (st_q != SP_IDLE && busy_i) begin
            st_d  = SP_IDLE;
            cnt_d = '0;
        end else if (tick_i) begin
            case (st_q)
                SP_WAIT: begin
                    if (cnt_q == DLY_LAST) begin
                        st_d  = SP_PULSE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                SP_PULSE: begin
                    if (cnt_q == WID_LAST) begin
                        st_d  = SP_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SP_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign stop_o = (st_q == SP_PULSE) && !busy_i;

    AST_STOP_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (st_q != SP_IDLE && busy_i && !play_end_i) |=> (st_q == SP_IDLE)); // R8
    AST_STOP_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == SP_PULSE) |-> (cnt_q <= WID_LAST)); // R6
    AST_STOP_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
        (st_q == SP_PULSE && !$past(play_end_i) && $past(st_q) != SP_PULSE)
            |-> $past(st_q == SP_WAIT && tick_i)); // R5
    AST_STOP_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (play_end_i && !stop_en_i) |=> (st_q == SP_IDLE)); // R7

endmodule

// File: rtl/led_flasher.sv
module led_flasher #(
    parameter int unsigned LED_HALF = 1333
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic busy_i,
    output logic led_a_o,
    output logic led_b_o
);
    localparam int unsigned LW = $clog2(LED_HALF + 1);
    localparam logic [LW-1:0] HALF_LAST = LW'(LED_HALF - 1);

    logic [LW-1:0] cnt_q;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst || !busy_i) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q == HALF_LAST) begin
                cnt_q   <= '0;
                phase_q <= !phase_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign led_a_o = busy_i &  phase_q;
    assign led_b_o = busy_i & ~phase_q;

    AST_LED_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !busy_i |=> !phase_q); // R11
    AST_LED_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= HALF_LAST); // R9
    AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_i) && busy_i && !$past(tick_i)) |-> $stable(phase_q)); // R9

endmodule

// File: rtl/play_status_gen.sv
module play_status_gen
    import play_status_pkg::*;
#(
    parameter int unsigned STOP_DELAY = 2,
    parameter int unsigned STOP_WIDTH = 512,
    parameter int unsigned LED_HALF   = 1333
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       busy_i,
    input  logic       play_end_i,
    input  logic       stop_en_i,
    input  logic [1:0] opt_i,
    output logic [2:0] pins_o
);
    status_sig_t sig;

    stop_pulse_gen #(
        .STOP_DELAY(STOP_DELAY),
        .STOP_WIDTH(STOP_WIDTH)
    ) u_stop (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .busy_i    (busy_i),
        .play_end_i(play_end_i),
        .stop_en_i (stop_en_i),
        .stop_o    (sig.stop)
    );

    led_flasher #(
        .LED_HALF(LED_HALF)
    ) u_led (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .busy_i (busy_i),
        .led_a_o(sig.led_a),
        .led_b_o(sig.led_b)
    );

    assign sig.busy = busy_i;
    assign pins_o   = route_pins(opt_i, sig);

    AST_LED_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> (sig.led_a != sig.led_b)); // R10
    AST_STOP_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !sig.stop); // R8

endmodule

// File: tb/tb_play_status_gen.sv
`timescale 1ns/100ps
module tb_play_status_gen;
    localparam int DLY  = 2;
    localparam int WID  = 5;
    localparam int HALF = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       busy = 1'b0;
    logic       pend = 1'b0;
    logic       sen  = 1'b0;
    logic [1:0] opt  = 2'd0;
    logic [2:0] pins;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    play_status_gen #(.STOP_DELAY(DLY), .STOP_WIDTH(WID), .LED_HALF(HALF)) dut (
        .clk(clk), .rst(rst), .tick_i(tick), .busy_i(busy),
        .play_end_i(pend), .stop_en_i(sen), .opt_i(opt), .pins_o(pins)
    );

    function automatic logic [2:0] exp_pins(int o, bit b, bit l1, bit st);
        bit la, lb;
        la = b & l1;
        lb = b & ~l1;
        case (o)
            2:       return {lb, la, st};
            3:       return {st, b, la};
            default: return {b, la, lb};
        endcase
    endfunction

    task automatic sweep(string tag, bit b, bit l1, bit st);
        for (int o = 0; o < 4; o++) begin
            logic [2:0] e;
            opt = 2'(o);
            #0.4;
            e = exp_pins(o, b, l1, st);
            n_chk++;
            if (pins !== e) begin
                n_fail++;
                $display("FAIL %s opt=%0d actual=%b expected=%b", tag, o, pins, e);
            end
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic end_event(bit en);
        @(negedge clk) begin busy = 1'b0; pend = 1'b1; sen = en; end
        @(negedge clk) begin pend = 1'b0; sen = 1'b0; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        sweep("R12 reset state", 0, 0, 0);

        // R4 R9 R10 R1 R2 R3: flash sweep while busy
        @(negedge clk) busy = 1'b1;
        sweep("R4/R9 busy start", 1, 0, 0);
        for (int k = 1; k <= 4 * HALF + 1; k++) begin
            do_tick();
            sweep("R9/R10 led phase", 1, 1'((k / HALF) % 2), 0);
        end
        // R11: idle clears LEDs at once, restart phase
        @(negedge clk) busy = 1'b0;
        #0.4 sweep("R11 idle low", 0, 0, 0);
        do_tick();
        @(negedge clk) busy = 1'b1;
        sweep("R11 restart phase", 1, 0, 0);
        for (int k = 1; k <= HALF; k++) begin
            do_tick();
            sweep("R11 restart count", 1, 1'((k / HALF) % 2), 0);
        end

        // R5 R6: full stop sequence
        end_event(1'b1);
        sweep("R5 armed", 0, 0, 0);
        for (int k = 1; k <= DLY + WID + 2; k++) begin
            do_tick();
            sweep("R5/R6 stop timing", 0, 0, (k >= DLY) && (k < DLY + WID));
        end

        // R7: disabled group
        end_event(1'b0);
        for (int k = 1; k <= DLY + WID; k++) begin
            do_tick();
            sweep("R7 stop disabled", 0, 0, 0);
        end
        // R7: disabled event cancels a pending sequence
        end_event(1'b1);
        do_tick();
        end_event(1'b0);
        for (int k = 1; k <= DLY + WID; k++) begin
            do_tick();
            sweep("R7 cancel pending", 0, 0, 0);
        end

        // R8: new playback cuts pulse at once
        end_event(1'b1);
        for (int k = 1; k <= DLY + 1; k++) do_tick();
        sweep("R8 pulse live", 0, 0, 1);
        @(negedge clk) busy = 1'b1;
        sweep("R8 cut same cycle", 1, 0, 0);
        do_tick();
        @(negedge clk) busy = 1'b0;
        for (int k = 1; k <= WID; k++) begin
            do_tick();
            sweep("R8 abandoned", 0, 0, 0);
        end
        // R8: busy during wait phase
        end_event(1'b1);
        @(negedge clk) busy = 1'b1;
        @(negedge clk) busy = 1'b0;
        for (int k = 1; k <= DLY + WID; k++) begin
            do_tick();
            sweep("R8 wait cancel", 0, 0, 0);
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule